// File: doc/BRIEF.md
# Mode-Banked CPU Register File

This block holds the general-purpose and control registers of a small 32-bit CPU core. Sixteen logical general registers are addressed by a 4-bit number. Registers 8 to 15 have a single physical copy. Registers 0 to 7 have two physical copies, called bank 0 and bank 1. The processor mode and a bank-select flag, both fields of the status register, decide which copy the normal ports see.

The decode and execute logic reads through two combinational ports and writes through one port that updates on the clock edge. Logical register 0 is also driven on its own output so that indexed address generation can use it at any time. A second, narrow port lets privileged code reach the copy of registers 0 to 7 that the normal ports cannot currently see. A control-register port reads and writes the status, global base, multiply-accumulate pair, return address, program counter and the privileged-only save and base registers. In user mode, an access to a privileged-only register, or any use of the alternate-bank port, is refused and reported with a one-cycle fault pulse.

Mode and bank changes are made by writing the status register through the control port. They take effect from the next clock cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register in both banks and in the shared set reads zero, and every control register reads zero except status, which reads 0x6000_0000 (privileged, bank 1). `priv_o`=1, `bank_sel_o`=1, and both fault outputs are 0.
- R2: Logical registers 8 to 15 have one physical copy. A value written in any mode or bank setting reads back unchanged in every other setting.
- R3: In user mode (`priv_o`=0), logical registers 0 to 7 use bank 0 for reads, writes and `r0_index`, whatever the value of `bank_sel_o`.
- R4: In privileged mode, logical registers 0 to 7 use bank 1 when `bank_sel_o`=1 and bank 0 when `bank_sel_o`=0.
- R5: In privileged mode the alternate-bank port (3-bit `alt_idx`, `alt_req`, `alt_wr`=1 for a write) reaches the bank the normal ports do not use. A read returns that register in the same cycle, and a write lands at the clock edge. Otherwise `alt_rdata` is zero.
- R6: In user mode an alternate-bank request writes nothing and reads zero, and `alt_fault` is 1 in the cycle after the request only.
- R7: Read ports are combinational and the write port updates at the clock edge. A read of the register being written in the same cycle returns the old value, and the new value appears from the next cycle.
- R8: `r0_index` always equals logical register 0 of the bank that is currently in use.
- R9: Control select codes: 0 status, 1 global base, 2 multiply high, 3 multiply low, 4 return address, 5 program counter, all usable in every mode. Codes 8 saved status, 9 saved PC, 10 vector base, 11 saved R15 and 12 debug base are privileged-only. Codes 6, 7, 13, 14 and 15 read zero, ignore writes and never fault. `ctl_rdata` is zero unless a read (`ctl_req`=1, `ctl_wr`=0) is presented.
- R10: In user mode an access to codes 8 to 12 leaves the register unchanged and reads zero. `ctl_fault` is then 1 in the following cycle only.
- R11: Status bit 30 is the mode (1 = privileged) and bit 29 is the bank select. They are shown on `priv_o` and `bank_sel_o`. The status register can be written in any mode, and the new mode and bank take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| r0_index | output | 32 | Logical register 0 of the bank in use |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| alt_req | input | 1 | Alternate-bank access request |
| alt_wr | input | 1 | Alternate-bank direction, 1 = write |
| alt_idx | input | 3 | Alternate-bank register slot |
| alt_wdata | input | 32 | Alternate-bank write data |
| alt_rdata | output | 32 | Alternate-bank read data |
| alt_fault | output | 1 | Alternate-bank request refused in user mode |
| ctl_req | input | 1 | Control register access request |
| ctl_wr | input | 1 | Control access direction, 1 = write |
| ctl_sel | input | 4 | Control register select code |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data |
| ctl_fault | output | 1 | Privileged-only control access refused |
| priv_o | output | 1 | Current mode, 1 = privileged |
| bank_sel_o | output | 1 | Current bank-select flag |

## Verification
The bench fills both banks with distinct values and then reads them back after every mode and bank change. A design that decoded the bank from the select flag alone, ignoring the mode, would return bank 1 data in user mode, and a design that pointed the alternate port at the same bank as the normal ports would return the visible value instead of the hidden one. The bench makes user-mode alternate-port writes and privileged-register writes, then returns to privileged mode and reads the targets back. A leaky gate would show up as a changed value, and a level or late fault instead of a one-cycle pulse would show up as a fault-output mismatch. It also reads and writes the same register in one cycle, and checks the unused select codes, where a wrong design would return the new data, stale contents or a false fault.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Width of the control register select code
  localparam int CSEL_W = 4;

  // Status register field positions decoded by the bank logic
  localparam int MODE_BIT = 30;
  localparam int BANK_BIT = 29;

  typedef enum logic [CSEL_W-1:0] {
    CS_STAT  = 4'd0,
    CS_GBASE = 4'd1,
    CS_MHI   = 4'd2,
    CS_MLO   = 4'd3,
    CS_RET   = 4'd4,
    CS_PCTR  = 4'd5,
    CS_SSTAT = 4'd8,
    CS_SPCTR = 4'd9,
    CS_VBASE = 4'd10,
    CS_SGR15 = 4'd11,
    CS_DBASE = 4'd12
  } ctl_sel_e;

  function automatic logic ctl_priv_only(input logic [CSEL_W-1:0] s);
    return (s >= CS_SSTAT) && (s <= CS_DBASE);
  endfunction

  function automatic logic ctl_exists(input logic [CSEL_W-1:0] s);
    return (s <= CS_PCTR) || ctl_priv_only(s);
  endfunction

endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map (
  input  logic priv,
  input  logic bank_flag,
  output logic act_bank,
  output logic alt_bank,
  output logic user
);

  // Bank 1 is in use only when privileged with the flag set
  always_comb begin
    act_bank = priv & bank_flag;
    alt_bank = ~act_bank;
    user     = ~priv;
  end

endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int DATA_W  = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act_bank,
  input  logic                         alt_bank,
  input  logic [$clog2(NGPR)-1:0]      rd_a_idx,
  input  logic [$clog2(NGPR)-1:0]      rd_b_idx,
  input  logic                         wr_en,
  input  logic [$clog2(NGPR)-1:0]      wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         alt_we,
  input  logic [$clog2(NBANKED)-1:0]   alt_idx,
  input  logic [DATA_W-1:0]            alt_wdata,
  output logic [DATA_W-1:0]            rd_a_data,
  output logic [DATA_W-1:0]            rd_b_data,
  output logic [DATA_W-1:0]            r0_data,
  output logic [DATA_W-1:0]            alt_rdata
);

  localparam int IDX_W   = $clog2(NGPR);
  localparam int SLOT_W  = $clog2(NBANKED);
  localparam int NSHARED = NGPR - NBANKED;
  localparam int SH_W    = (NSHARED > 1) ? $clog2(NSHARED) : 1;
  localparam logic [IDX_W-1:0] BANKED_LIM = IDX_W'(NBANKED);

  logic [DATA_W-1:0] bank_q   [2][NBANKED];
  logic              bank_we  [2][NBANKED];
  logic [DATA_W-1:0] bank_d   [2][NBANKED];
  logic [DATA_W-1:0] shared_q [NSHARED];
  logic              shared_we[NSHARED];

  logic wr_banked;
  assign wr_banked = wr_idx < BANKED_LIM;

  // Next-state: per-register enables; the normal port wins a slot tie
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < NBANKED; i++) begin
        logic hit_n;
        logic hit_a;
        hit_n = wr_en && wr_banked && (wr_idx[SLOT_W-1:0] == SLOT_W'(i)) &&
                (act_bank == b[0]);
        hit_a = alt_we && (alt_idx == SLOT_W'(i)) && (alt_bank == b[0]);
        bank_we[b][i] = hit_n | hit_a;
        bank_d[b][i]  = hit_n ? wr_data : alt_wdata;
      end
    end
    for (int j = 0; j < NSHARED; j++) begin
      shared_we[j] = wr_en && (wr_idx == IDX_W'(NBANKED + j));
    end
  end

  // Storage
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NBANKED; i++) begin : g_slot
      logic [DATA_W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             q_r <= '0;
        else if (bank_we[b][i]) q_r <= bank_d[b][i];
      end
      assign bank_q[b][i] = q_r;
    end
  end

  for (genvar j = 0; j < NSHARED; j++) begin : g_shared
    logic [DATA_W-1:0] q_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q_r <= '0;
      else if (shared_we[j]) q_r <= wr_data;
    end
    assign shared_q[j] = q_r;
  end

  function automatic logic [DATA_W-1:0] read_logical(input logic [IDX_W-1:0] idx);
    if (idx < BANKED_LIM) return bank_q[act_bank][idx[SLOT_W-1:0]];
    else                  return shared_q[SH_W'(idx - BANKED_LIM)];
  endfunction

  always_comb begin
    rd_a_data = read_logical(rd_a_idx);
    rd_b_data = read_logical(rd_b_idx);
    r0_data   = bank_q[act_bank][0];
    alt_rdata = bank_q[alt_bank][alt_idx];
  end

endmodule

// File: rtl/rf_ctl_regs.sv
module rf_ctl_regs
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSEL_W-1:0] sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              priv,
  output logic              bank_flag
);

  localparam int NSLOT = 1 << CSEL_W;
  localparam logic [DATA_W-1:0] STAT_RESET =
    (DATA_W'(1) << MODE_BIT) | (DATA_W'(1) << BANK_BIT);

  logic [DATA_W-1:0] slot_q  [NSLOT];
  logic              slot_we [NSLOT];

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_we[s] = wr_en && (sel == CSEL_W'(s));
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (ctl_exists(CSEL_W'(s))) begin : g_reg
      localparam logic [DATA_W-1:0] RST_VAL = (s == 0) ? STAT_RESET : '0;
      logic [DATA_W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q_r <= RST_VAL;
        else if (slot_we[s]) q_r <= wdata;
      end
      assign slot_q[s] = q_r;
    end else begin : g_none
      assign slot_q[s] = '0;
    end
  end

  always_comb begin
    rdata     = slot_q[sel];
    priv      = slot_q[CS_STAT][MODE_BIT];
    bank_flag = slot_q[CS_STAT][BANK_BIT];
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NGPR)-1:0]     rd_a_idx,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [$clog2(NGPR)-1:0]     rd_b_idx,
  output logic [DATA_W-1:0]           rd_b_data,
  output logic [DATA_W-1:0]           r0_index,
  input  logic                        wr_en,
  input  logic [$clog2(NGPR)-1:0]     wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        alt_req,
  input  logic                        alt_wr,
  input  logic [$clog2(NBANKED)-1:0]  alt_idx,
  input  logic [DATA_W-1:0]           alt_wdata,
  output logic [DATA_W-1:0]           alt_rdata,
  output logic                        alt_fault,
  input  logic                        ctl_req,
  input  logic                        ctl_wr,
  input  logic [CSEL_W-1:0]           ctl_sel,
  input  logic [DATA_W-1:0]           ctl_wdata,
  output logic [DATA_W-1:0]           ctl_rdata,
  output logic                        ctl_fault,
  output logic                        priv_o,
  output logic                        bank_sel_o
);

  localparam int IDX_W  = $clog2(NGPR);
  localparam int SLOT_W = $clog2(NBANKED);

  logic rst_sync_n;
  logic priv, bank_flag, act_bank, alt_bank, user;
  logic [DATA_W-1:0] alt_raw, ctl_raw;

  rf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rf_bank_map u_map (
    .priv      (priv),
    .bank_flag (bank_flag),
    .act_bank  (act_bank),
    .alt_bank  (alt_bank),
    .user      (user)
  );

  // Access gating
  logic ctl_block, ctl_we_ok, ctl_rd_ok, alt_ok, alt_we_ok;
  always_comb begin
    ctl_block = user && ctl_priv_only(ctl_sel);
    ctl_we_ok = ctl_req && ctl_wr && !ctl_block;
    ctl_rd_ok = ctl_req && !ctl_wr && !ctl_block;
    alt_ok    = alt_req && !user;
    alt_we_ok = alt_ok && alt_wr;
  end

  rf_gpr_array #(
    .DATA_W  (DATA_W),
    .NGPR    (NGPR),
    .NBANKED (NBANKED)
  ) u_gpr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act_bank  (act_bank),
    .alt_bank  (alt_bank),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .alt_we    (alt_we_ok),
    .alt_idx   (alt_idx),
    .alt_wdata (alt_wdata),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .r0_data   (r0_index),
    .alt_rdata (alt_raw)
  );

  rf_ctl_regs #(
    .DATA_W (DATA_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (ctl_sel),
    .wr_en     (ctl_we_ok),
    .wdata     (ctl_wdata),
    .rdata     (ctl_raw),
    .priv      (priv),
    .bank_flag (bank_flag)
  );

  always_comb begin
    ctl_rdata  = ctl_rd_ok ? ctl_raw : '0;
    alt_rdata  = (alt_ok && !alt_wr) ? alt_raw : '0;
    priv_o     = priv;
    bank_sel_o = bank_flag;
  end

  // Fault pulses: next-state and register
  logic alt_fault_d, ctl_fault_d, alt_fault_q, ctl_fault_q;
  always_comb begin
    alt_fault_d = alt_req && user;
    ctl_fault_d = ctl_req && ctl_block;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      alt_fault_q <= 1'b0;
      ctl_fault_q <= 1'b0;
    end else begin
      alt_fault_q <= alt_fault_d;
      ctl_fault_q <= ctl_fault_d;
    end
  end

  assign alt_fault = alt_fault_q;
  assign ctl_fault = ctl_fault_q;

endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              priv,
  input logic              alt_req,
  input logic              alt_wr,
  input logic [DATA_W-1:0] alt_rdata,
  input logic              alt_fault,
  input logic              ctl_req,
  input logic              ctl_wr,
  input logic [CSEL_W-1:0] ctl_sel,
  input logic [DATA_W-1:0] ctl_rdata,
  input logic              ctl_fault,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] r0_index
);

  logic sr_write;
  assign sr_write = ctl_req && ctl_wr && (ctl_sel == CS_STAT);

  a_r6_alt_user_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && alt_req) |-> (alt_rdata == '0));

  a_r6_alt_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && alt_req) |=> alt_fault);

  a_r5_alt_priv_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (priv && alt_req) |=> !alt_fault);

  a_r6_alt_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    alt_fault |-> ($past(alt_req) && !$past(priv)));

  a_r10_ctl_user_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && ctl_req && ctl_priv_only(ctl_sel)) |-> (ctl_rdata == '0));

  a_r10_ctl_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && ctl_req && ctl_priv_only(ctl_sel)) |=> ctl_fault);

  a_r10_ctl_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fault |-> ($past(ctl_req) && !$past(priv)));

  a_r9_idle_ctl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_req || ctl_wr) |-> (ctl_rdata == '0));

  a_r8_index_port: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (r0_index == rd_a_data));

  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == rd_a_idx) && !sr_write) |=>
      ((rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(wr_data))));

  logic unused_alt_wr;
  assign unused_alt_wr = alt_wr;

endmodule

bind banked_regfile rf_checker #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .priv      (priv_o),
  .alt_req   (alt_req),
  .alt_wr    (alt_wr),
  .alt_rdata (alt_rdata),
  .alt_fault (alt_fault),
  .ctl_req   (ctl_req),
  .ctl_wr    (ctl_wr),
  .ctl_sel   (ctl_sel),
  .ctl_rdata (ctl_rdata),
  .ctl_fault (ctl_fault),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .r0_index  (r0_index)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, ctl_sel;
  logic [31:0] rd_a_data, rd_b_data, r0_index, wr_data, alt_wdata, alt_rdata;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        wr_en, alt_req, alt_wr, ctl_req, ctl_wr;
  logic [2:0]  alt_idx;
  logic        alt_fault, ctl_fault, priv_o, bank_sel_o;

  always #4 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .r0_index(r0_index),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_req(alt_req), .alt_wr(alt_wr), .alt_idx(alt_idx),
    .alt_wdata(alt_wdata), .alt_rdata(alt_rdata), .alt_fault(alt_fault),
    .ctl_req(ctl_req), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_fault(ctl_fault),
    .priv_o(priv_o), .bank_sel_o(bank_sel_o)
  );

  // Behavioural reference state
  logic [31:0] m_bank [2][8];
  logic [31:0] m_shr  [8];
  logic [31:0] m_ctl  [16];
  logic        m_priv, m_bank_sel, e_alt_f, e_ctl_f;

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic m_act();
    return m_priv & m_bank_sel;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] idx);
    if (idx < 4'd8) return m_bank[m_act()][idx[2:0]];
    return m_shr[idx[2:0]];
  endfunction

  function automatic logic is_priv_code(input logic [3:0] s);
    return (s >= 4'd8) && (s <= 4'd12);
  endfunction

  function automatic logic is_real_code(input logic [3:0] s);
    return (s <= 4'd5) || is_priv_code(s);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) m_bank[b][i] = '0;
    for (int i = 0; i < 8; i++) m_shr[i] = '0;
    for (int i = 0; i < 16; i++) m_ctl[i] = '0;
    m_ctl[0]   = 32'h6000_0000;
    m_priv     = 1'b1;
    m_bank_sel = 1'b1;
    e_alt_f    = 1'b0;
    e_ctl_f    = 1'b0;
  endtask

  task automatic idle_in();
    rd_a_idx = '0; rd_b_idx = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    alt_req = 1'b0; alt_wr = 1'b0; alt_idx = '0; alt_wdata = '0;
    ctl_req = 1'b0; ctl_wr = 1'b0; ctl_sel = '0; ctl_wdata = '0;
  endtask

  // Called at a falling edge with inputs already driven
  task automatic tick(input string tag);
    logic        act, blocked, e_alt_t, e_ctl_t;
    logic [31:0] e_alt, e_ctl;
    #1;
    act     = m_act();
    blocked = !m_priv && is_priv_code(ctl_sel);
    e_alt   = (alt_req && !alt_wr && m_priv) ? m_bank[!act][alt_idx] : 32'h0;
    e_ctl   = (ctl_req && !ctl_wr && !blocked) ? m_ctl[ctl_sel] : 32'h0;
    chk(tag, "rd_a_data", rd_a_data, m_read(rd_a_idx));
    chk(tag, "rd_b_data", rd_b_data, m_read(rd_b_idx));
    chk("R8", "r0_index", r0_index, m_bank[act][0]);
    chk(tag, "alt_rdata", alt_rdata, e_alt);
    chk(tag, "ctl_rdata", ctl_rdata, e_ctl);
    @(posedge clk);
    e_alt_t = alt_req && !m_priv;
    e_ctl_t = ctl_req && blocked;
    if (alt_req && alt_wr && m_priv) m_bank[!act][alt_idx] = alt_wdata;
    if (wr_en) begin
      if (wr_idx < 4'd8) m_bank[act][wr_idx[2:0]] = wr_data;
      else               m_shr[wr_idx[2:0]] = wr_data;
    end
    if (ctl_req && ctl_wr && !blocked && is_real_code(ctl_sel))
      m_ctl[ctl_sel] = ctl_wdata;
    m_priv     = m_ctl[0][30];
    m_bank_sel = m_ctl[0][29];
    e_alt_f    = e_alt_t;
    e_ctl_f    = e_ctl_t;
    @(negedge clk);
    chk(tag, "alt_fault", {31'h0, alt_fault}, {31'h0, e_alt_f});
    chk(tag, "ctl_fault", {31'h0, ctl_fault}, {31'h0, e_ctl_f});
    chk(tag, "priv_o", {31'h0, priv_o}, {31'h0, m_priv});
    chk(tag, "bank_sel_o", {31'h0, bank_sel_o}, {31'h0, m_bank_sel});
    idle_in();
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      alt_req = 1'b1; alt_wr = 1'b0; alt_idx = 3'(i);
      tick(tag);
    end
  endtask

  task automatic ctl_write(input logic [3:0] s, input logic [31:0] v, input string tag);
    ctl_req = 1'b1; ctl_wr = 1'b1; ctl_sel = s; ctl_wdata = v;
    tick(tag);
  endtask

  task automatic ctl_read_all(input string tag);
    for (int s = 0; s < 16; s++) begin
      ctl_req = 1'b1; ctl_wr = 1'b0; ctl_sel = 4'(s);
      tick(tag);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset contents and status
    read_all("R1");
    ctl_read_all("R1");

    // R4: privileged, bank 1 in use; fill all sixteen
    for (int i = 0; i < 16; i++) begin
      wr_en = 1'b1; wr_idx = 4'(i); wr_data = 32'h1000_0000 + 32'(i * 17);
      tick("R4");
    end
    read_all("R4");

    // R5: alternate port reaches bank 0
    for (int i = 0; i < 8; i++) begin
      alt_req = 1'b1; alt_wr = 1'b1; alt_idx = 3'(i);
      alt_wdata = 32'hA0A0_0000 | 32'(i);
      rd_a_idx = 4'(i);
      tick("R5");
    end
    read_all("R5");

    // R7: same-cycle read of the written register returns old value
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    tick("R7");
    wr_en = 1'b1; wr_idx = 4'd11; wr_data = 32'hDEAD_000B;
    rd_a_idx = 4'd11; rd_b_idx = 4'd3;
    tick("R7");
    rd_a_idx = 4'd11; rd_b_idx = 4'd3;
    tick("R7");

    // R11: switch to bank 0 while privileged
    ctl_write(4'd0, 32'h4000_0000, "R11");
    read_all("R4");

    // R9: control register map in privileged mode
    for (int s = 1; s < 16; s++) ctl_write(4'(s), 32'hC000_0000 | 32'(s), "R9");
    ctl_read_all("R9");

    // R3: user mode with bank flag set still uses bank 0
    ctl_write(4'd0, 32'h2000_0000, "R11");
    read_all("R3");
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h5555_0002;
    tick("R3");
    wr_en = 1'b1; wr_idx = 4'd12; wr_data = 32'h5555_000C;
    tick("R2");

    // R6: alternate port refused in user mode
    alt_req = 1'b1; alt_wr = 1'b1; alt_idx = 3'd2; alt_wdata = 32'hBAD0_0002;
    tick("R6");
    alt_req = 1'b1; alt_wr = 1'b0; alt_idx = 3'd5;
    tick("R6");
    tick("R6");

    // R10: privileged-only registers refused in user mode
    ctl_write(4'd8, 32'hBAD0_0008, "R10");
    ctl_req = 1'b1; ctl_wr = 1'b0; ctl_sel = 4'd9;
    tick("R10");
    tick("R10");
    ctl_read_all("R9");

    // R11: user code returns to privileged, bank 1
    ctl_write(4'd0, 32'h6000_0000, "R11");
    read_all("R6");
    ctl_read_all("R10");
    rd_a_idx = 4'd12;
    tick("R2");

    // R1: second reset clears everything
    do_reset();
    read_all("R1");
    ctl_read_all("R1");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule